// File: doc/BRIEF.md
# DMA Channel Autoinitialization Controller

This block keeps the control state of a single DMA logical channel and decides what the channel does each time a block transfer finishes. It holds two copies of the transfer context, made up of source address, destination address and length. Software writes the programming set. The active set drives the transfer engine. A four-bit control register selects among four outcomes at the end of a block: the channel stops, waits pending, restarts with its previous context, or reloads a new context.

The channel never keeps a physical channel between blocks. Before every block it raises a request to an external scheduler. It waits for a one-cycle grant, then pulses a start strobe to the transfer engine. The engine answers with a one-cycle end-of-transfer pulse. The block has no data path, so every pin is a plain control or status line with no valid/ready handshake. The scheduler and engine sit outside the block.

Top module: `dma_chan_autoinit`

## Requirements
- R1: After reset, chan_state is 0 (idle), ctl_q is 0, the active set is 0, and sched_req, xfer_start and blk_done are low.
- R2: ctl_we loads ctl_wdata into the control register, which reads back on ctl_q. The fields are: bit 0 enable, bit 1 autoinit, bit 2 repeat, bit 3 reload (copy a new context). chan_state encodes idle=0, request=1, active=2, pending=3.
- R3: In idle with enable set, the channel moves to request. The grant that follows a start from idle copies the programming set into the active set.
- R4: In request, sched_req stays high until sched_gnt is seen. The grant moves the channel to active, and xfer_start is high for exactly the one cycle after the grant.
- R5: In active, xfer_done makes blk_done high for the one following cycle, whatever action follows. xfer_done has no effect outside active, and sched_gnt has no effect outside request.
- R6: If a block ends with autoinit clear, the channel returns to idle and the hardware clears enable.
- R7: If a block ends with autoinit set and both repeat and reload clear, the channel goes to pending with sched_req low. It leaves pending for request once software sets repeat or reload.
- R8: If a block ends with autoinit and repeat set and reload clear, the channel requests again. At the grant the active set stays unchanged.
- R9: If a block ends with autoinit and reload set, the channel requests again whatever repeat is. At the grant the programming set is copied into the active set and the hardware clears reload.
- R10: Every new block passes through request and waits for its own grant. xfer_start never rises without a grant in the previous cycle.
- R11: In pending, a cleared enable bit returns the channel to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: enable, autoinit, repeat, reload |
| ctl_q | output | 4 | Control register contents |
| prog_we | input | 1 | Programming set write strobe |
| prog_src | input | AW | Programmed source address |
| prog_dst | input | AW | Programmed destination address |
| prog_len | input | LW | Programmed block length |
| sched_req | output | 1 | Request for a physical channel |
| sched_gnt | input | 1 | One-cycle grant from the scheduler |
| xfer_start | output | 1 | One-cycle start strobe to the engine |
| act_src | output | AW | Active source address |
| act_dst | output | AW | Active destination address |
| act_len | output | LW | Active block length |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse |
| blk_done | output | 1 | One-cycle block-complete flag |
| chan_state | output | 2 | Channel state code |

## Verification
The assertions check the handshake rules on every cycle: a request is held until it is granted, a start follows a grant and lasts one cycle, a completion flag follows an end pulse in active, pending never requests, and the idle and pending exits clear the expected state. Which context is active after a grant can only be shown by the bench. It proves a restart keeps the old context and a reload or fresh start takes the new one, by changing the programming set between blocks and reading the active set. The bench scenarios also show that reload overrides repeat and clears itself, and that stray grants and end pulses are ignored.

// File: rtl/dma_autoinit_pkg.sv
package dma_autoinit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACT  = 2'd2,
    ST_PEND = 2'd3
  } chan_st_e;

  // bit 3 reload, bit 2 repeat, bit 1 autoinit, bit 0 enable
  typedef struct packed {
    logic reload;
    logic rpt;
    logic autoi;
    logic en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_autoinit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wr_data,
  input  logic clr_en,
  input  logic clr_reload,
  output ctl_t ctl
);

  // A software write in the same cycle takes precedence over a hardware clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl <= wr_data;
    end else begin
      if (clr_en)     ctl.en     <= 1'b0;
      if (clr_reload) ctl.reload <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_ctx_bank.sv
module dma_ctx_bank #(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_src,
  input  logic [AW-1:0] prog_dst,
  input  logic [LW-1:0] prog_len,
  input  logic          copy,
  output logic [AW-1:0] act_src,
  output logic [AW-1:0] act_dst,
  output logic [LW-1:0] act_len
);

  localparam int CW = 2 * AW + LW;

  logic [CW-1:0] prog_q;
  logic [CW-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (prog_we) begin
      prog_q <= {prog_src, prog_dst, prog_len};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (copy) begin
      act_q <= prog_q;
    end
  end

  assign act_src = act_q[CW-1 -: AW];
  assign act_dst = act_q[LW +: AW];
  assign act_len = act_q[LW-1:0];

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_autoinit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_t     ctl,
  input  logic     sched_gnt,
  input  logic     xfer_done,
  output chan_st_e state,
  output logic     sched_req,
  output logic     xfer_start,
  output logic     blk_done,
  output logic     copy,
  output logic     clr_en,
  output logic     clr_reload
);

  chan_st_e state_q, state_d;
  logic     fresh_q, fresh_d;
  logic     start_q, done_q;
  logic     granted, ended;

  assign granted = (state_q == ST_REQ) && sched_gnt;
  assign ended   = (state_q == ST_ACT) && xfer_done;

  always_comb begin
    state_d    = state_q;
    fresh_d    = fresh_q;
    copy       = 1'b0;
    clr_en     = 1'b0;
    clr_reload = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ctl.en) begin
          state_d = ST_REQ;
          fresh_d = 1'b1;
        end
      end
      ST_REQ: begin
        if (sched_gnt) begin
          state_d    = ST_ACT;
          fresh_d    = 1'b0;
          copy       = fresh_q || ctl.reload;
          clr_reload = ctl.reload;
        end
      end
      ST_ACT: begin
        if (xfer_done) begin
          if (!ctl.autoi) begin
            state_d = ST_IDLE;
            clr_en  = 1'b1;
          end else if (ctl.reload || ctl.rpt) begin
            state_d = ST_REQ;
          end else begin
            state_d = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (!ctl.en) begin
          state_d = ST_IDLE;
        end else if (ctl.reload || ctl.rpt) begin
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fresh_q <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fresh_q <= fresh_d;
      start_q <= granted;
      done_q  <= ended;
    end
  end

  assign state      = state_q;
  assign sched_req  = (state_q == ST_REQ);
  assign xfer_start = start_q;
  assign blk_done   = done_q;

endmodule

// File: rtl/dma_chan_autoinit.sv
module dma_chan_autoinit
  import dma_autoinit_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             prog_we,
  input  logic [AW-1:0]    prog_src,
  input  logic [AW-1:0]    prog_dst,
  input  logic [LW-1:0]    prog_len,
  output logic             sched_req,
  input  logic             sched_gnt,
  output logic             xfer_start,
  output logic [AW-1:0]    act_src,
  output logic [AW-1:0]    act_dst,
  output logic [LW-1:0]    act_len,
  input  logic             xfer_done,
  output logic             blk_done,
  output logic [1:0]       chan_state
);

  ctl_t     ctl;
  chan_st_e state;
  logic     copy, clr_en, clr_reload;

  dma_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctl_we),
    .wr_data    (ctl_t'(ctl_wdata)),
    .clr_en     (clr_en),
    .clr_reload (clr_reload),
    .ctl        (ctl)
  );

  dma_ctx_bank #(.AW(AW), .LW(LW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (prog_we),
    .prog_src (prog_src),
    .prog_dst (prog_dst),
    .prog_len (prog_len),
    .copy     (copy),
    .act_src  (act_src),
    .act_dst  (act_dst),
    .act_len  (act_len)
  );

  dma_chan_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .sched_gnt  (sched_gnt),
    .xfer_done  (xfer_done),
    .state      (state),
    .sched_req  (sched_req),
    .xfer_start (xfer_start),
    .blk_done   (blk_done),
    .copy       (copy),
    .clr_en     (clr_en),
    .clr_reload (clr_reload)
  );

  assign ctl_q      = ctl;
  assign chan_state = state;

endmodule

// File: rtl/dma_chan_autoinit_chk.sv
module dma_chan_autoinit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [3:0] ctl_q,
  input logic       sched_req,
  input logic       sched_gnt,
  input logic       xfer_start,
  input logic       xfer_done,
  input logic       blk_done,
  input logic [1:0] chan_state
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ACT  = 2'd2;
  localparam logic [1:0] S_PEND = 2'd3;

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_req && !sched_gnt) |=> sched_req);

  p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  p_start_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_start) |-> $past(sched_req && sched_gnt));

  p_done_follows_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_done) |-> $past(xfer_done && chan_state == S_ACT));

  p_noauto_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == S_ACT && xfer_done && !ctl_q[1] && !ctl_we)
      |=> (chan_state == S_IDLE && !ctl_q[0]));

  p_pending_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == S_PEND) |-> !sched_req);

  p_pending_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == S_PEND && !ctl_q[0] && !ctl_we) |=> (chan_state == S_IDLE));

endmodule

bind dma_chan_autoinit dma_chan_autoinit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_q      (ctl_q),
  .sched_req  (sched_req),
  .sched_gnt  (sched_gnt),
  .xfer_start (xfer_start),
  .xfer_done  (xfer_done),
  .blk_done   (blk_done),
  .chan_state (chan_state)
);

// File: tb/dma_chan_autoinit_tb.sv
module dma_chan_autoinit_tb;

  localparam int AW = 16;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic [3:0]    ctl_q;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_src = '0;
  logic [AW-1:0] prog_dst = '0;
  logic [LW-1:0] prog_len = '0;
  logic          sched_req;
  logic          sched_gnt = 1'b0;
  logic          xfer_start;
  logic [AW-1:0] act_src, act_dst;
  logic [LW-1:0] act_len;
  logic          xfer_done = 1'b0;
  logic          blk_done;
  logic [1:0]    chan_state;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_chan_autoinit #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .prog_we(prog_we), .prog_src(prog_src),
    .prog_dst(prog_dst), .prog_len(prog_len), .sched_req(sched_req),
    .sched_gnt(sched_gnt), .xfer_start(xfer_start), .act_src(act_src),
    .act_dst(act_dst), .act_len(act_len), .xfer_done(xfer_done),
    .blk_done(blk_done), .chan_state(chan_state)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_prog(input logic [AW-1:0] s);
    @(negedge clk);
    prog_we = 1'b1; prog_src = s; prog_dst = s + 16'h0100; prog_len = 12'h040;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic grant_blk(input logic [AW-1:0] exp_src, input string tag);
    int w = 0;
    while (!sched_req && w < 50) begin
      @(negedge clk); w++;
    end
    check({tag, " R4 req"}, 32'(sched_req), 32'd1);
    sched_gnt = 1'b1;
    @(negedge clk);
    sched_gnt = 1'b0;
    check({tag, " R4 start"}, 32'(xfer_start), 32'd1);
    check({tag, " R4 state"}, 32'(chan_state), 32'd2);
    check({tag, " R3/R8/R9 src"}, 32'(act_src), 32'(exp_src));
    @(negedge clk);
    check({tag, " R4 start width"}, 32'(xfer_start), 32'd0);
  endtask

  task automatic end_blk(input logic [1:0] exp_st, input logic [3:0] exp_ctl, input string tag);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check({tag, " R5 blk_done"}, 32'(blk_done), 32'd1);
    check({tag, " R6/R7/R8/R9 state"}, 32'(chan_state), 32'(exp_st));
    check({tag, " R2/R6/R9 ctl"}, 32'(ctl_q), 32'(exp_ctl));
  endtask

  typedef struct packed {
    logic          wr;
    logic [3:0]    ctl;
    logic [AW-1:0] src;
    logic [AW-1:0] exp_src;
    logic [1:0]    exp_st;
    logic [3:0]    exp_ctl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h1, 16'h0010, 16'h0010, 2'd0, 4'h0},  // R3 R6 fresh, no autoinit
    '{1'b1, 4'h7, 16'h0020, 16'h0020, 2'd1, 4'h7},  // R3 R8 fresh then repeat
    '{1'b0, 4'h0, 16'h0030, 16'h0020, 2'd1, 4'h7},  // R8 old context kept
    '{1'b1, 4'hF, 16'h0040, 16'h0040, 2'd1, 4'h7},  // R9 reload beats repeat
    '{1'b1, 4'h3, 16'h0050, 16'h0040, 2'd3, 4'h3},  // R7 to pending
    '{1'b1, 4'hB, 16'h0060, 16'h0060, 2'd3, 4'h3},  // R7 R9 reload from pending
    '{1'b1, 4'h7, 16'h0070, 16'h0060, 2'd1, 4'h7},  // R8 repeat
    '{1'b1, 4'h1, 16'h0080, 16'h0060, 2'd0, 4'h0}   // R6 autoinit off
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", 32'(chan_state), 32'd0);
    check("R1 ctl", 32'(ctl_q), 32'd0);
    check("R1 act", 32'(act_src), 32'd0);
    check("R1 req/start/done", {29'd0, sched_req, xfer_start, blk_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d", i);
      wr_prog(VECS[i].src);
      if (VECS[i].wr) wr_ctl(VECS[i].ctl);
      grant_blk(VECS[i].exp_src, tag);
      end_blk(VECS[i].exp_st, VECS[i].exp_ctl, tag);
    end
    check("R1 act_dst", 32'(act_dst), 32'h0160);
    check("R1 act_len", 32'(act_len), 32'h040);

    // R5 end pulse and grant ignored in idle
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R5 done ignored idle", 32'(blk_done), 32'd0);
    sched_gnt = 1'b1;
    @(negedge clk);
    sched_gnt = 1'b0;
    check("R5 gnt ignored idle", 32'(xfer_start), 32'd0);
    check("R5 idle held", 32'(chan_state), 32'd0);

    // R10 request waits for its own grant
    wr_prog(16'h0090);
    wr_ctl(4'h3);
    check("R2 ctl readback", 32'(ctl_q), 32'h3);
    @(negedge clk);
    repeat (6) @(negedge clk);
    check("R10 still requesting", 32'(chan_state), 32'd1);
    check("R10 req held", 32'(sched_req), 32'd1);
    check("R10 no start", 32'(xfer_start), 32'd0);
    grant_blk(16'h0090, "R3 fresh");
    end_blk(2'd3, 4'h3, "R7 pend");

    // R7 pending stays put without repeat/reload
    repeat (4) @(negedge clk);
    check("R7 pending held", 32'(chan_state), 32'd3);
    check("R7 no req", 32'(sched_req), 32'd0);

    // R11 clear enable in pending
    wr_ctl(4'h2);
    @(negedge clk);
    check("R11 back to idle", 32'(chan_state), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule